// File: doc/BRIEF.md
# Watchdog Control Register with Write-Once Lock

This block is a single 16-bit control register that sits beside a system watchdog and an interrupt router. Software writes it through a plain write strobe with a data word and reads it back as a whole word. The bits in the register do not all behave alike. One is a lock that can be set but never cleared by software. One halts the watchdog counter. One is a message-send request that hardware clears. One redirects NMIs to SMIs. One raises a software NMI and toggles on each write of 1.

The watchdog counter, the message transmitter and the bus bridge are outside this block. Each of them meets the block at a simple level or pulse. The block gates write requests aimed at an external watchdog-enable bit. It passes or blocks alert messages according to the halt bit. It holds a send request until a done pulse arrives. It turns NMI sources into single-cycle NMI or SMI pulses.

Top module: `wdog_ctl_reg`

## Requirements
- R1: After reset the readback is 0000h. Bits 15:13 and 7:0 always read as 0, and writing 1 to them changes no readback bit and no output.
- R2: Bit 12 (lock) is set by a write with bit 12 = 1. A write with bit 12 = 0 leaves it at 1. Only reset clears it.
- R3: `en_wr_ok` follows `en_wr_req` in the same cycle while lock is 0, and stays 0 while lock is 1.
- R4: Bit 11 (halt) is plain read/write and drives `tmr_halt`. `alert_go` equals `alert_req` only while halt is 0. `beat_go` equals `beat_req` whatever the halt bit holds.
- R5: Bit 10 (send) is set by a write with bit 10 = 1, and a write with bit 10 = 0 leaves it unchanged. A `send_done` pulse clears it. When a done pulse and a write of 1 arrive in the same cycle, the bit ends up 0. `send_req` mirrors the bit.
- R6: Bit 9 (redirect) is plain read/write. While it is 0, each rising edge of the NMI source sampled at a clock edge gives `nmi_pulse` = 1 for the one cycle after that edge.
- R7: While redirect is 1, no `nmi_pulse` is produced. A rising edge of the NMI source gives `smi_pulse` one cycle later, but only when `gbl_smi_en` = 1 and `nmi_block` = 0 at that edge.
- R8: Bit 8 (software NMI) flips on every write with bit 8 = 1 and ignores writes with bit 8 = 0. While it is 1 it drives the NMI source high, so setting it yields one routed pulse two edges after the write.
- R9: The NMI source is `nmi_in` OR bit 8. A source that stays high gives only one pulse, and `nmi_pulse` and `smi_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register readback |
| en_wr_req | input | 1 | Request to write the external watchdog-enable bit |
| en_wr_ok | output | 1 | Gated write enable for that bit |
| tmr_halt | output | 1 | Halt level to the watchdog counter |
| alert_req | input | 1 | Alert message request |
| alert_go | output | 1 | Alert request passed on |
| beat_req | input | 1 | Heartbeat message request |
| beat_go | output | 1 | Heartbeat request passed on |
| send_req | output | 1 | Software-event send request level |
| send_done | input | 1 | One-cycle completion pulse from the message engine |
| nmi_in | input | 1 | Hardware NMI source level |
| gbl_smi_en | input | 1 | Global SMI enable |
| nmi_block | input | 1 | NMI-enable input; 1 blocks redirected SMIs |
| nmi_pulse | output | 1 | One-cycle NMI pulse |
| smi_pulse | output | 1 | One-cycle SMI pulse |

## Verification
Register bits and the levels derived from them (`tmr_halt`, `send_req`, the gate on `en_wr_ok` and `alert_go`) change right after the edge that takes the write or the done pulse. The pass-through paths are combinational in the same cycle. A hardware NMI edge gives its pulse right after the edge that samples it. A software NMI gives its pulse one edge later, because the bit must first be stored. The bench updates a behavioural model at each rising edge and compares every output a quarter period later, so each result is checked in the cycle it is due.

// File: rtl/wdc_pkg.sv
// Package: shared widths and bit positions of the watchdog control register.
// Assumes the register is one word; bit positions are fixed because
// software decodes them.
package wdc_pkg;
    localparam int REG_W   = 16;
    localparam int LOCK_B  = 12;
    localparam int HALT_B  = 11;
    localparam int SEND_B  = 10;
    localparam int REDIR_B = 9;
    localparam int SWNMI_B = 8;
    localparam int N_PLAIN = 2;
    localparam int PLAIN_POS [N_PLAIN] = '{HALT_B, REDIR_B};
endpackage

// File: rtl/wdc_bits.sv
// Module: storage for the live bits of the control register.
// Mixes plain read/write bits, a sticky lock, a hardware-cleared request
// and a write-1-toggle trigger. Assumes writes are whole-word single-cycle
// strobes and send_done is a one-cycle pulse.
module wdc_bits
    import wdc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         send_done,
    output logic         lock_q,
    output logic [N_PLAIN-1:0] plain_q,
    output logic         send_q,
    output logic         swnmi_q
);
    // Plain read/write bits, one flop each
    genvar gi;
    generate
        for (gi = 0; gi < N_PLAIN; gi++) begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)     plain_q[gi] <= 1'b0;
                else if (wr_en) plain_q[gi] <= wr_data[PLAIN_POS[gi]];
            end
        end
    endgenerate

    // Lock: set-only from software, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)                          lock_q <= 1'b0;
        else if (wr_en && wr_data[LOCK_B])   lock_q <= 1'b1;
    end

    // Send request: completion pulse takes priority over a new write of 1
    always_ff @(posedge clk) begin
        if (!rst_n)                          send_q <= 1'b0;
        else if (send_done)                  send_q <= 1'b0;
        else if (wr_en && wr_data[SEND_B])   send_q <= 1'b1;
    end

    // Software NMI: each write of 1 flips the bit, a write of 0 does nothing
    always_ff @(posedge clk) begin
        if (!rst_n)                          swnmi_q <= 1'b0;
        else if (wr_en && wr_data[SWNMI_B])  swnmi_q <= ~swnmi_q;
    end
endmodule

// File: rtl/wdc_route.sv
// Module: NMI edge detection and NMI/SMI routing.
// Combines the hardware source with the software trigger, finds rising
// edges and sends each one out as a single-cycle NMI or a gated SMI.
// Assumes all inputs are synchronous to clk.
module wdc_route (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic swnmi,
    input  logic redir,
    input  logic gbl_smi_en,
    input  logic nmi_block,
    output logic nmi_pulse,
    output logic smi_pulse
);
    logic src;
    logic src_q;
    logic rise;

    // Source level and its rising edge
    always_comb begin
        src  = nmi_in | swnmi;
        rise = src & ~src_q;
    end

    // Remember last source level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    // Registered routing of each edge to exactly one output or none
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pulse <= 1'b0;
            smi_pulse <= 1'b0;
        end else begin
            nmi_pulse <= rise & ~redir;
            smi_pulse <= rise & redir & gbl_smi_en & ~nmi_block;
        end
    end
endmodule

// File: rtl/wdog_ctl_reg.sv
// Module: watchdog control register top.
// Holds the control bits, assembles the readback word, gates the external
// enable write and the alert path, and routes NMI sources. Assumes a
// single-register port with no address decode and a synchronous
// active-low reset.
module wdog_ctl_reg
    import wdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             en_wr_req,
    output logic             en_wr_ok,
    output logic             tmr_halt,
    input  logic             alert_req,
    output logic             alert_go,
    input  logic             beat_req,
    output logic             beat_go,
    output logic             send_req,
    input  logic             send_done,
    input  logic             nmi_in,
    input  logic             gbl_smi_en,
    input  logic             nmi_block,
    output logic             nmi_pulse,
    output logic             smi_pulse
);
    logic               lock_q;
    logic [N_PLAIN-1:0] plain_q;
    logic               send_q;
    logic               swnmi_q;
    logic               halt_q;
    logic               redir_q;

    wdc_bits #(.W(REG_W)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .send_done (send_done),
        .lock_q    (lock_q),
        .plain_q   (plain_q),
        .send_q    (send_q),
        .swnmi_q   (swnmi_q)
    );

    wdc_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_in     (nmi_in),
        .swnmi      (swnmi_q),
        .redir      (redir_q),
        .gbl_smi_en (gbl_smi_en),
        .nmi_block  (nmi_block),
        .nmi_pulse  (nmi_pulse),
        .smi_pulse  (smi_pulse)
    );

    // Name the plain bits by their role
    always_comb begin
        halt_q  = plain_q[0];
        redir_q = plain_q[1];
    end

    // Readback word: live bits in place, everything else zero
    always_comb begin
        rd_data          = '0;
        rd_data[LOCK_B]  = lock_q;
        rd_data[HALT_B]  = halt_q;
        rd_data[SEND_B]  = send_q;
        rd_data[REDIR_B] = redir_q;
        rd_data[SWNMI_B] = swnmi_q;
    end

    // Side outputs derived from the control bits
    always_comb begin
        en_wr_ok = en_wr_req & ~lock_q;
        tmr_halt = halt_q;
        alert_go = alert_req & ~halt_q;
        beat_go  = beat_req;
        send_req = send_q;
    end
endmodule

// File: rtl/wdc_chk.sv
// Module: assertion checker for wdog_ctl_reg, attached by bind below.
// Observes ports only; assumes the same clock and reset as the top.
module wdc_chk
    import wdc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] rd_data,
    input logic             en_wr_ok,
    input logic             alert_go,
    input logic             send_done,
    input logic             nmi_pulse,
    input logic             smi_pulse,
    input logic             gbl_smi_en,
    input logic             nmi_block
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15:13] == 3'b000) && (rd_data[7:0] == 8'h00));
    // R2
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[LOCK_B] |=> rd_data[LOCK_B]);
    // R3
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[LOCK_B] |-> !en_wr_ok);
    // R4
    alert_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[HALT_B] |-> !alert_go);
    // R5
    done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_done |=> !rd_data[SEND_B]);
    // R7
    smi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gbl_smi_en == 1'b0) |=> !smi_pulse);
    // R9
    nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |=> !nmi_pulse);
    // R9
    smi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |=> !smi_pulse);
    // R9
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_pulse && smi_pulse));
    // R7
    smi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_block |=> !smi_pulse);
endmodule

bind wdog_ctl_reg wdc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_data    (rd_data),
    .en_wr_ok   (en_wr_ok),
    .alert_go   (alert_go),
    .send_done  (send_done),
    .nmi_pulse  (nmi_pulse),
    .smi_pulse  (smi_pulse),
    .gbl_smi_en (gbl_smi_en),
    .nmi_block  (nmi_block)
);

// File: tb/wdog_ctl_reg_bench.sv
module wdog_ctl_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        en_wr_req = 1'b0, en_wr_ok;
    logic        tmr_halt;
    logic        alert_req = 1'b0, alert_go;
    logic        beat_req = 1'b0, beat_go;
    logic        send_req;
    logic        send_done = 1'b0;
    logic        nmi_in = 1'b0, gbl_smi_en = 1'b0, nmi_block = 1'b0;
    logic        nmi_pulse, smi_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // reference model state
    bit m_lock, m_halt, m_send, m_redir, m_sw, m_srcq, m_nmi, m_smi;

    wdog_ctl_reg u_wdog_ctl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .en_wr_req(en_wr_req), .en_wr_ok(en_wr_ok),
        .tmr_halt(tmr_halt), .alert_req(alert_req), .alert_go(alert_go),
        .beat_req(beat_req), .beat_go(beat_go), .send_req(send_req),
        .send_done(send_done), .nmi_in(nmi_in), .gbl_smi_en(gbl_smi_en),
        .nmi_block(nmi_block), .nmi_pulse(nmi_pulse), .smi_pulse(smi_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // model update at each rising edge
    always @(posedge clk) begin
        bit src, rise, nsend;
        cycles++;
        if (!rst_n) begin
            {m_lock, m_halt, m_send, m_redir, m_sw, m_srcq, m_nmi, m_smi} = '0;
        end else begin
            src   = nmi_in || m_sw;
            rise  = src && !m_srcq;
            m_nmi = rise && !m_redir;
            m_smi = rise && m_redir && gbl_smi_en && !nmi_block;
            m_srcq = src;
            nsend = m_send;
            if (wr_en && wr_data[10]) nsend = 1;
            if (send_done) nsend = 0;
            m_send = nsend;
            if (wr_en) begin
                if (wr_data[12]) m_lock = 1;
                m_halt  = wr_data[11];
                m_redir = wr_data[9];
                if (wr_data[8]) m_sw = !m_sw;
            end
        end
    end

    // compare a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !finished) begin
            chk("R1 reserved", {rd_data[15:13], rd_data[7:0]}, 0);
            chk("R2 lock", rd_data[12], m_lock);
            chk("R3 en_wr_ok", en_wr_ok, en_wr_req && !m_lock);
            chk("R4 halt", rd_data[11], m_halt);
            chk("R4 tmr_halt", tmr_halt, m_halt);
            chk("R4 alert_go", alert_go, alert_req && !m_halt);
            chk("R4 beat_go", beat_go, beat_req);
            chk("R5 send", rd_data[10], m_send);
            chk("R5 send_req", send_req, m_send);
            chk("R6 redirect", rd_data[9], m_redir);
            chk("R8 swnmi", rd_data[8], m_sw);
            chk("R6 nmi_pulse", nmi_pulse, m_nmi);
            chk("R7 smi_pulse", smi_pulse, m_smi);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // watchdog: an expired run counts as a failure
    initial begin
        wait (cycles > WD_LIMIT);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cycles, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset readback
        chk("R1 reset value", rd_data, 0);
        // R1 reserved-only write
        wr(16'hE0FF); tick(2);
        // R3 gate open before lock
        en_wr_req = 1; tick(2); en_wr_req = 0;
        // R4 halt and message paths
        alert_req = 1; beat_req = 1; tick(1);
        wr(16'h0800); tick(2);
        wr(16'h0000); tick(2);
        alert_req = 0; beat_req = 0;
        // R5 send, write 0 ignored, done clears
        wr(16'h0400); tick(2);
        wr(16'h0000); tick(2);
        send_done = 1; tick(1); send_done = 0; tick(1);
        // R5 done and write in the same cycle
        wr(16'h0400); tick(1);
        send_done = 1; wr_en = 1; wr_data = 16'h0400; tick(1);
        send_done = 0; wr_en = 0; wr_data = 0; tick(2);
        // R6 hardware NMI, redirect off, held high
        nmi_in = 1; tick(4); nmi_in = 0; tick(2);
        // R7 redirect on, all gate combinations
        wr(16'h0200);
        for (int k = 0; k < 4; k++) begin
            gbl_smi_en = k[0]; nmi_block = k[1];
            nmi_in = 1; tick(2); nmi_in = 0; tick(2);
        end
        gbl_smi_en = 0; nmi_block = 0;
        wr(16'h0000); tick(1);
        // R8 software NMI toggle, write 0 ignored, hw overlap
        wr(16'h0100); tick(3);
        wr(16'h0000); tick(2);
        nmi_in = 1; tick(2); nmi_in = 0;
        wr(16'h0100); tick(3);
        wr(16'h0100); tick(3);
        // R2 lock set, write 0 does not clear; R3 gate closed
        wr(16'h1000); tick(1);
        wr(16'h0000); tick(1);
        en_wr_req = 1; tick(2); en_wr_req = 0;
        wr(16'hFFFF); tick(3);
        wr(16'h0000); tick(3);
        // R2 only reset clears lock
        rst_n = 0; tick(2); rst_n = 1; tick(1);
        chk("R2 lock after reset", rd_data[12], 0);
        tick(2);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule